// File: doc/BRIEF.md
# Queue Doorbell Decoder

This block sits behind the register window of a queue-based storage controller and turns host writes into queue pointer updates. Each write in the doorbell area either moves the tail of a submission ring or the head of a completion ring. The block keeps one pointer register per ring and, after a write that is accepted, pulses a per-queue wake-up line so that the fetch engine or the completion poster can resume. It never reads or writes ring memory itself.

A submission tail write wakes that submission queue. A completion head write that frees space in a ring that was full wakes the completion poster for that ring. It also wakes every valid submission queue whose binding input names that ring, since those queues may have stalled on it. If entries are still waiting after the head moves (the tail that the poster supplies is not equal to the new head), the block raises a one-cycle interrupt request tagged with the ring index.

Top module: `qdoorbell_decoder`

## Requirements
- R1: A write is a doorbell only when its address is at least 0x1000 and its two low address bits are zero; any other write changes no pointer and produces no pulse.
- R2: With off = address - 0x1000, bit 2 of off selects the ring kind (0 = submission tail, 1 = completion head) and off >> 3 is the queue index; an index of NUM_Q or more is ignored.
- R3: The new pointer is bits 15:0 of the write data; bits 31:16 have no effect.
- R4: A write to a queue whose valid flag is low, or whose pointer is greater than or equal to that queue's size, changes no pointer and produces no pulse.
- R5: An accepted submission tail write stores the pointer and drives sqKick high for that queue alone, for exactly the one cycle after the write edge.
- R6: An accepted completion head write on a ring that was full before it (tail + 1, wrapping to 0 at the ring size, equals the old head) pulses cqKick for that ring and sqKick for every valid submission queue bound to that ring, in the cycle after the write edge.
- R7: After an accepted completion head write, irqReq pulses for one cycle with irqQid set to the ring index when the ring's tail differs from the new head, and stays low otherwise.
- R8: All pointers are zero after reset, and the pointer of any queue whose valid flag is low is cleared to zero on the next edge.
- R9: An accepted completion head write on a ring that was not full updates the head but pulses no kick line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 32 | Write data |
| sqValid | input | NUM_Q | Submission queue exists |
| cqValid | input | NUM_Q | Completion queue exists |
| sqSize | input | NUM_Q x 16 | Entries in each submission ring |
| cqSize | input | NUM_Q x 16 | Entries in each completion ring |
| sqBind | input | NUM_Q x QID_W | Completion ring each submission queue posts to |
| cqTail | input | NUM_Q x 16 | Completion ring tails kept by the poster |
| sqTail | output | NUM_Q x 16 | Submission tail pointers |
| cqHead | output | NUM_Q x 16 | Completion head pointers |
| sqKick | output | NUM_Q | One-cycle wake-up per submission queue |
| cqKick | output | NUM_Q | One-cycle wake-up of the poster per completion ring |
| irqReq | output | 1 | One-cycle interrupt request |
| irqQid | output | QID_W | Ring index of the interrupt request |

## Verification
A completion head write on a full ring makes the wake-up fan-out and the interrupt request fall in the same cycle, with several submission kicks raised together with the poster kick. The bench holds every completion tail fixed and walks the head upward through each ring, so the step off the slot just after the tail meets the full condition while the head still differs from the tail. One more case sets the tail to the last slot so that the full test must wrap. In each of those cycles the whole sqKick vector, cqKick, irqReq and irqQid are compared with values computed from the binding table.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int PTR_W = 16;

  // Strobes from decode/validate to the pointer store
  typedef struct packed {
    logic              sqWr;
    logic              cqWr;
    logic              wake;
    logic              irq;
    logic [15:0]       qid;
    logic [PTR_W-1:0]  ptr;
  } dbStrobe_t;
endpackage

// File: rtl/qdb_ctrl.sv
module qdb_ctrl
  import qdb_pkg::*;
#(
  parameter int NUM_Q   = 64,
  parameter int ADDR_W  = 16,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [31:0]                   wrData,
  input  logic [NUM_Q-1:0]              sqValid,
  input  logic [NUM_Q-1:0]              cqValid,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   sqSize,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   cqSize,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   cqTail,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   cqHead,
  output dbStrobe_t                     strb
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DB_BASE);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-4:0] qidWide;
  logic [QID_W-1:0]  qid;
  logic [PTR_W-1:0]  ptr;
  logic              inWindow, inRange, isCq;
  logic [PTR_W:0]    tailInc;
  logic [PTR_W-1:0]  tailNext;
  logic              unusedHi;

  assign unusedHi = ^wrData[31:PTR_W];

  assign off      = wrAddr - BASE;
  assign inWindow = wrEn && (wrAddr >= BASE) && (off[1:0] == 2'b00);
  assign isCq     = off[2];
  assign qidWide  = off[ADDR_W-1:3];
  assign inRange  = qidWide < (ADDR_W-3)'(NUM_Q);
  assign qid      = qidWide[QID_W-1:0];
  assign ptr      = wrData[PTR_W-1:0];

  // Ring-full test on the completion ring before the head moves
  assign tailInc  = {1'b0, cqTail[qid]} + 1'b1;
  assign tailNext = (tailInc == {1'b0, cqSize[qid]}) ? '0 : tailInc[PTR_W-1:0];

  always_comb begin
    strb      = '0;
    strb.qid  = 16'(qid);
    strb.ptr  = ptr;
    if (inWindow && inRange) begin
      if (!isCq) begin
        strb.sqWr = sqValid[qid] && (ptr < sqSize[qid]);
      end else if (cqValid[qid] && (ptr < cqSize[qid])) begin
        strb.cqWr = 1'b1;
        strb.wake = (tailNext == cqHead[qid]);
        strb.irq  = (ptr != cqTail[qid]);
      end
    end
  end
endmodule

// File: rtl/qdb_data.sv
module qdb_data
  import qdb_pkg::*;
#(
  parameter int NUM_Q  = 64,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  dbStrobe_t                     strb,
  input  logic [NUM_Q-1:0]              sqValid,
  input  logic [NUM_Q-1:0]              cqValid,
  input  logic [NUM_Q-1:0][QID_W-1:0]   sqBind,
  output logic [NUM_Q-1:0][PTR_W-1:0]   sqTail,
  output logic [NUM_Q-1:0][PTR_W-1:0]   cqHead,
  output logic [NUM_Q-1:0]              sqKick,
  output logic [NUM_Q-1:0]              cqKick,
  output logic                          irqReq,
  output logic [QID_W-1:0]              irqQid
);
  logic [QID_W-1:0] qi;
  logic [NUM_Q-1:0] boundMask;
  logic             unusedQid;

  assign qi        = strb.qid[QID_W-1:0];
  assign unusedQid = ^strb.qid[15:QID_W];

  // Submission queues that post to the addressed completion ring
  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : gBind
      assign boundMask[i] = sqValid[i] && (sqBind[i] == qi);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sqTail <= '0;
      cqHead <= '0;
      sqKick <= '0;
      cqKick <= '0;
      irqReq <= 1'b0;
      irqQid <= '0;
    end else begin
      sqKick <= '0;
      cqKick <= '0;
      irqReq <= 1'b0;
      for (int q = 0; q < NUM_Q; q++) begin
        if (!sqValid[q]) sqTail[q] <= '0;
        if (!cqValid[q]) cqHead[q] <= '0;
      end
      if (strb.sqWr) begin
        sqTail[qi] <= strb.ptr;
        sqKick[qi] <= 1'b1;
      end
      if (strb.cqWr) begin
        cqHead[qi] <= strb.ptr;
        irqReq     <= strb.irq;
        irqQid     <= qi;
        if (strb.wake) begin
          cqKick[qi] <= 1'b1;
          sqKick     <= boundMask;
        end
      end
    end
  end
endmodule

// File: rtl/qdoorbell_decoder.sv
module qdoorbell_decoder
  import qdb_pkg::*;
#(
  parameter int NUM_Q   = 64,
  parameter int ADDR_W  = 16,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [31:0]                   wrData,
  input  logic [NUM_Q-1:0]              sqValid,
  input  logic [NUM_Q-1:0]              cqValid,
  input  logic [NUM_Q-1:0][15:0]        sqSize,
  input  logic [NUM_Q-1:0][15:0]        cqSize,
  input  logic [NUM_Q-1:0][QID_W-1:0]   sqBind,
  input  logic [NUM_Q-1:0][15:0]        cqTail,
  output logic [NUM_Q-1:0][15:0]        sqTail,
  output logic [NUM_Q-1:0][15:0]        cqHead,
  output logic [NUM_Q-1:0]              sqKick,
  output logic [NUM_Q-1:0]              cqKick,
  output logic                          irqReq,
  output logic [QID_W-1:0]              irqQid
);
  dbStrobe_t strb;

  qdb_ctrl #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DB_BASE(DB_BASE)) uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sqValid(sqValid), .cqValid(cqValid),
    .sqSize(sqSize), .cqSize(cqSize),
    .cqTail(cqTail), .cqHead(cqHead),
    .strb(strb)
  );

  qdb_data #(.NUM_Q(NUM_Q)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .sqValid(sqValid), .cqValid(cqValid), .sqBind(sqBind),
    .sqTail(sqTail), .cqHead(cqHead),
    .sqKick(sqKick), .cqKick(cqKick),
    .irqReq(irqReq), .irqQid(irqQid)
  );
endmodule

// File: rtl/qdb_checker.sv
module qdb_checker #(
  parameter int NUM_Q = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wrEn,
  input logic [NUM_Q-1:0]        sqValid,
  input logic [NUM_Q-1:0][15:0]  sqSize,
  input logic [NUM_Q-1:0][15:0]  sqTail,
  input logic [NUM_Q-1:0]        sqKick,
  input logic [NUM_Q-1:0]        cqKick,
  input logic                    irqReq
);
  AST_CQKICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cqKick)); // R6
  AST_KICK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sqKick) || (|cqKick)) |-> $past(wrEn)); // R5
  AST_IRQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> $past(wrEn)); // R7

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : gQ
      AST_TAIL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sqValid[q] && $past(sqValid[q]) && $stable(sqSize[q])) |-> (sqTail[q] < sqSize[q])); // R4
      AST_INVALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sqValid[q]) |-> (sqTail[q] == 16'd0)); // R8
      AST_TAIL_MOVE_KICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sqValid[q]) && (sqTail[q] != $past(sqTail[q]))) |-> sqKick[q]); // R5
    end
  endgenerate
endmodule

bind qdoorbell_decoder qdb_checker #(.NUM_Q(NUM_Q)) uChk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn),
  .sqValid(sqValid), .sqSize(sqSize), .sqTail(sqTail),
  .sqKick(sqKick), .cqKick(cqKick), .irqReq(irqReq)
);

// File: tb/qdoorbell_decoder_test.sv
module qdoorbell_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;
  localparam int QW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [NQ-1:0] sqV = 8'b1101_1011;
  logic [NQ-1:0] cqV = 8'b0111_0110;
  logic [NQ-1:0][15:0] sqSz, cqSz, cqT;
  logic [NQ-1:0][QW-1:0] bind_;
  logic [NQ-1:0][15:0] sqTail, cqHead;
  logic [NQ-1:0] sqKick, cqKick;
  logic irqReq;
  logic [QW-1:0] irqQid;

  logic [NQ-1:0][15:0] mSq, mCq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdoorbell_decoder #(.NUM_Q(NQ), .ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sqValid(sqV), .cqValid(cqV), .sqSize(sqSz), .cqSize(cqSz),
    .sqBind(bind_), .cqTail(cqT), .sqTail(sqTail), .cqHead(cqHead),
    .sqKick(sqKick), .cqKick(cqKick), .irqReq(irqReq), .irqQid(irqQid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [31:0] d);
    string tag;
    logic [NQ-1:0] expSqK = '0;
    logic [NQ-1:0] expCqK = '0;
    bit expIrq = 1'b0;
    bit isDb = (a >= 16'h1000) && (a[1:0] == 2'b00);
    int off = int'(a) - 'h1000;
    int q = off >>> 3;
    bit isCq = off[2];
    int p = int'(d[15:0]);
    if (!isDb) tag = "R1";
    else if (q >= NQ) tag = "R2";
    else if (!isCq) begin
      if (!sqV[q] || p >= int'(sqSz[q])) tag = "R4";
      else begin tag = "R5"; mSq[q] = 16'(p); expSqK[q] = 1'b1; end
    end else begin
      if (!cqV[q] || p >= int'(cqSz[q])) tag = "R4";
      else begin
        int nx = (int'(cqT[q]) + 1) % int'(cqSz[q]);
        bit full = (nx == int'(mCq[q]));
        mCq[q] = 16'(p);
        expIrq = (p != int'(cqT[q]));
        if (full) begin
          tag = "R6";
          expCqK[q] = 1'b1;
          for (int i = 0; i < NQ; i++)
            if (sqV[i] && int'(bind_[i]) == q) expSqK[i] = 1'b1;
        end else tag = "R9";
      end
    end
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
    chk(sqTail == mSq, tag, "sqTail", 128'(sqTail), 128'(mSq));
    chk(cqHead == mCq, tag, "cqHead", 128'(cqHead), 128'(mCq));
    chk(sqKick == expSqK, tag, "sqKick", 128'(sqKick), 128'(expSqK));
    chk(cqKick == expCqK, tag, "cqKick", 128'(cqKick), 128'(expCqK));
    chk(irqReq == expIrq, "R7", "irqReq", 128'(irqReq), 128'(expIrq));
    if (expIrq) chk(int'(irqQid) == q, "R7", "irqQid", 128'(irqQid), 128'(q));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin
      sqSz[i] = 16'(i + 2);
      cqSz[i] = 16'(i + 3);
      cqT[i] = 16'd1;
      bind_[i] = (i % 2 == 0) ? QW'(1) : QW'(2);
    end
    mSq = '0; mCq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk(sqTail == '0 && cqHead == '0, "R8", "reset ptrs", 128'(sqTail), 128'(0));
    chk(sqKick == '0 && cqKick == '0 && !irqReq, "R8", "reset pulses",
        128'({sqKick, cqKick, irqReq}), 128'(0));

    // R5/R4/R2: submission sweep incl. out-of-range index
    for (int q = 0; q <= NQ; q++)
      for (int p = 0; p <= int'(sqSz[q % NQ]) + 1; p++)
        doWrite(16'('h1000 + 8 * q), 32'(p));

    // R6/R7/R9/R4: completion sweep with tail fixed at 1
    for (int q = 0; q < NQ; q++)
      for (int p = 0; p <= int'(cqSz[q]); p++)
        doWrite(16'('h1004 + 8 * q), 32'(p));

    // R6: wrap in the full test (tail at last slot)
    cqT[5] = 16'd7;
    doWrite(16'h1004 + 16'd40, 32'd0);
    doWrite(16'h1004 + 16'd40, 32'd3);

    // R1: unaligned and below window
    doWrite(16'h1009, 32'd1);
    doWrite(16'h100A, 32'd1);
    doWrite(16'h0FF8, 32'd1);
    doWrite(16'h0FFC, 32'd1);

    // R3: upper data bits ignored
    doWrite(16'h1008, 32'hABCD_0002);
    chk(sqTail[1] == 16'd2, "R3", "upper bits", 128'(sqTail[1]), 128'(2));

    // R8: dropping valid clears pointers
    sqV[3] = 1'b0; cqV[4] = 1'b0;
    @(posedge clk); #1;
    mSq[3] = '0; mCq[4] = '0;
    chk(sqTail == mSq, "R8", "invalid sq cleared", 128'(sqTail), 128'(mSq));
    chk(cqHead == mCq, "R8", "invalid cq cleared", 128'(cqHead), 128'(mCq));
    @(negedge clk);
    doWrite(16'h1018, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule